// File: doc/BRIEF.md
# Banked Bridge Memory

This block is a memory with two faces. One face is a user port whose word is `DATA_W` bits wide, any width from 1 upward. The other face is a host register bus that moves 16-bit words. The user word is cut into 16-bit slices, and each slice is kept in a bank of its own with `DEPTH` entries. Every bank owns a window of `DEPTH` consecutive bus addresses above a build-time `BASE_ADDR`. A host can therefore reach any slice of any user word with ordinary 16-bit register accesses.

The bus side forms one stage in a chain of register targets. Every request that enters with `bus_in_valid` leaves `bus_out_*` exactly two cycles later, with its address and write flag unchanged. A read that lands inside the window, and that the build mode allows, has its data field replaced by the stored word. Every other request carries its data through untouched. The bus has no back-pressure. One request may enter per cycle, and the downstream stage must take each response in the cycle it is presented.

The `MODE` parameter fixes which side may write and which side may read. In bidirectional mode both sides can do both. In user-to-host mode the user side writes and the bus reads. In host-to-user mode the bus writes and the user side reads. All storage clears to zero on reset.

Top module: `bridge_mem`

## Requirements
- R1: After reset, every in-window bus read returns 0 (in modes where the bus reads), `usr_rdata` is 0 and `bus_out_valid` is 0.
- R2: Slice i of user entry A, meaning user bits [16i+15:16i], is held in bank i, which is reached on the bus at address `BASE_ADDR + A + i*DEPTH`. Bank 0 holds the least significant slice.
- R3: When `DATA_W` is not a multiple of 16, the top bank is `DATA_W mod 16` bits wide. A bus write to it drops the upper data bits, and a bus read from it returns the stored bits zero-extended to 16.
- R4: Each request accepted with `bus_in_valid`=1 appears on `bus_out_valid` exactly two clock cycles later, with `bus_out_addr` and `bus_out_write` equal to those of the request. `bus_out_valid` is high at no other time.
- R5: For a read request (`bus_in_write`=0) that hits the window in a bus-readable mode, `bus_out_data` is the stored word. For write requests, `bus_out_data` equals the request's data.
- R6: Requests with an address below `BASE_ADDR` or at or above `BASE_ADDR + NB*DEPTH` leave the memory unchanged and emerge with their data unchanged.
- R7: A user write takes place at the clock edge where `usr_we`=1. `usr_rdata` shows the entry addressed by `usr_addr` at the previous edge, and so is valid one cycle after the address is applied.
- R8: When the bus and the user side write the same entry at the same edge, the user data is stored.
- R9: `MODE`=2 (host-to-user): user writes have no effect, and bus reads pass their data through unchanged.
- R10: `MODE`=1 (user-to-host): bus writes have no effect, and `usr_rdata` is held at 0. `MODE`=0 is bidirectional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in_valid | input | 1 | Bus request present this cycle |
| bus_in_write | input | 1 | 1 = write, 0 = read |
| bus_in_addr | input | BUS_AW | Bus word address |
| bus_in_data | input | 16 | Write data, or the data that a read carries along |
| bus_out_valid | output | 1 | Forwarded request/response present |
| bus_out_write | output | 1 | Forwarded write flag |
| bus_out_addr | output | BUS_AW | Forwarded address |
| bus_out_data | output | 16 | Read result or forwarded data |
| usr_addr | input | IDX_W | User entry address, below DEPTH |
| usr_wdata | input | DATA_W | User write data |
| usr_we | input | 1 | User write enable |
| usr_rdata | output | DATA_W | User read data |

## Verification
The assertions assume that the inputs stay idle (no `bus_in_valid`, no `usr_we`) while reset is held, and that `usr_addr` stays below `DEPTH`. Under those assumptions, the two-cycle pipeline history that the properties inspect never reaches back into state that reset cleared. The stimulus holds every input at zero during reset and uses only entry indices 0 to 15. It drives each transaction on the falling edge and releases `bus_in_valid` after a single cycle. The same stimulus drives one instance per mode, so the mode restrictions are checked against the same traffic that exercises bidirectional mode.

// File: rtl/bridge_mem_pkg.sv
package bridge_mem_pkg;

  typedef enum logic [1:0] {
    BRIDGE_BIDIR        = 2'd0,
    BRIDGE_USER_TO_HOST = 2'd1,
    BRIDGE_HOST_TO_USER = 2'd2
  } bridge_mode_e;

  localparam int SLICE_W = 16;

  function automatic int bank_count(int data_w);
    return (data_w + SLICE_W - 1) / SLICE_W;
  endfunction

  function automatic int bank_width(int data_w, int bank);
    int n;
    n = bank_count(data_w);
    if (bank < n - 1) return SLICE_W;
    return data_w - SLICE_W * (n - 1);
  endfunction

endpackage

// File: rtl/bridge_bus_decode.sv
module bridge_bus_decode #(
  parameter int                BUS_AW    = 16,
  parameter logic [BUS_AW-1:0] BASE_ADDR = '0,
  parameter int                DEPTH     = 16,
  parameter int                NB        = 2,
  parameter int                IDX_W     = 4,
  parameter int                BSEL_W    = 1
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output logic [BSEL_W-1:0] bank,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [BUS_AW:0] LO   = {1'b0, BASE_ADDR};
  localparam logic [BUS_AW:0] SPAN = (BUS_AW+1)'(NB * DEPTH);
  localparam logic [BUS_AW:0] DEP  = (BUS_AW+1)'(DEPTH);

  logic [BUS_AW:0] off;
  logic [BUS_AW:0] quo;
  logic [BUS_AW:0] rem;

  always_comb begin
    off  = {1'b0, addr} - LO;
    hit  = !off[BUS_AW] && (off < SPAN);
    quo  = off / DEP;
    rem  = off % DEP;
    bank = quo[BSEL_W-1:0];
    idx  = rem[IDX_W-1:0];
  end
endmodule

// File: rtl/bridge_bank.sv
module bridge_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we,
  input  logic [IDX_W-1:0] h_widx,
  input  logic [W-1:0]     h_wdata,
  input  logic [IDX_W-1:0] h_ridx,
  output logic [W-1:0]     h_rdata,
  input  logic             u_we,
  input  logic [IDX_W-1:0] u_widx,
  input  logic [W-1:0]     u_wdata,
  input  logic [IDX_W-1:0] u_ridx,
  output logic [W-1:0]     u_rdata
);
  logic [W-1:0] cells [DEPTH];

  // Reads see the contents before this edge's writes; the user write is
  // applied last so it wins a same-entry collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) cells[e] <= '0;
      h_rdata <= '0;
      u_rdata <= '0;
    end else begin
      h_rdata <= cells[h_ridx];
      u_rdata <= cells[u_ridx];
      if (h_we) cells[h_widx] <= h_wdata;
      if (u_we) cells[u_widx] <= u_wdata;
    end
  end
endmodule

// File: rtl/bridge_mem.sv
module bridge_mem
  import bridge_mem_pkg::*;
#(
  parameter int                DATA_W    = 23,
  parameter int                DEPTH     = 16,
  parameter int                BUS_AW    = 16,
  parameter logic [BUS_AW-1:0] BASE_ADDR = 'h40,
  parameter bridge_mode_e      MODE      = BRIDGE_BIDIR,
  localparam int               IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_in_valid,
  input  logic              bus_in_write,
  input  logic [BUS_AW-1:0] bus_in_addr,
  input  logic [15:0]       bus_in_data,
  output logic              bus_out_valid,
  output logic              bus_out_write,
  output logic [BUS_AW-1:0] bus_out_addr,
  output logic [15:0]       bus_out_data,
  input  logic [IDX_W-1:0]  usr_addr,
  input  logic [DATA_W-1:0] usr_wdata,
  input  logic              usr_we,
  output logic [DATA_W-1:0] usr_rdata
);
  localparam int NB     = bank_count(DATA_W);
  localparam int BSEL_W = (NB > 1) ? $clog2(NB) : 1;
  localparam bit BUS_WR = (MODE != BRIDGE_USER_TO_HOST);
  localparam bit BUS_RD = (MODE != BRIDGE_HOST_TO_USER);
  localparam bit USR_WR = (MODE != BRIDGE_HOST_TO_USER);
  localparam bit USR_RD = (MODE != BRIDGE_USER_TO_HOST);

  logic              dec_hit;
  logic [BSEL_W-1:0] dec_bank;
  logic [IDX_W-1:0]  dec_idx;

  bridge_bus_decode #(
    .BUS_AW(BUS_AW), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH),
    .NB(NB), .IDX_W(IDX_W), .BSEL_W(BSEL_W)
  ) i_decode (
    .addr(bus_in_addr), .hit(dec_hit), .bank(dec_bank), .idx(dec_idx)
  );

  logic              bus_wr_hit;
  logic [15:0]       bank_hword [NB];
  logic [DATA_W-1:0] usr_raw;

  assign bus_wr_hit = BUS_WR && bus_in_valid && bus_in_write && dec_hit;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int BW = bank_width(DATA_W, b);
    logic [BW-1:0] h_rd;
    logic [BW-1:0] u_rd;

    bridge_bank #(.W(BW), .DEPTH(DEPTH), .IDX_W(IDX_W)) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_we   (bus_wr_hit && (dec_bank == BSEL_W'(b))),
      .h_widx (dec_idx),
      .h_wdata(bus_in_data[BW-1:0]),
      .h_ridx (dec_idx),
      .h_rdata(h_rd),
      .u_we   (USR_WR && usr_we),
      .u_widx (usr_addr),
      .u_wdata(usr_wdata[16*b +: BW]),
      .u_ridx (usr_addr),
      .u_rdata(u_rd)
    );

    assign bank_hword[b]         = 16'(h_rd);
    assign usr_raw[16*b +: BW]   = u_rd;
  end

  assign usr_rdata = USR_RD ? usr_raw : '0;

  // Stage 1: request captured alongside the bank read.
  logic              s1_valid;
  logic              s1_write;
  logic              s1_hit;
  logic [BSEL_W-1:0] s1_bank;
  logic [BUS_AW-1:0] s1_addr;
  logic [15:0]       s1_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_write <= 1'b0;
      s1_hit   <= 1'b0;
      s1_bank  <= '0;
      s1_addr  <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= bus_in_valid;
      if (bus_in_valid) begin
        s1_write <= bus_in_write;
        s1_hit   <= dec_hit;
        s1_bank  <= dec_bank;
        s1_addr  <= bus_in_addr;
        s1_data  <= bus_in_data;
      end
    end
  end

  logic [15:0] sel_word;
  logic        take_mem;

  always_comb begin
    sel_word = '0;
    for (int b = 0; b < NB; b++)
      if (s1_bank == BSEL_W'(b)) sel_word = bank_hword[b];
    take_mem = BUS_RD && s1_hit && !s1_write;
  end

  // Stage 2: response or forwarded request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out_valid <= 1'b0;
      bus_out_write <= 1'b0;
      bus_out_addr  <= '0;
      bus_out_data  <= '0;
    end else begin
      bus_out_valid <= s1_valid;
      if (s1_valid) begin
        bus_out_write <= s1_write;
        bus_out_addr  <= s1_addr;
        bus_out_data  <= take_mem ? sel_word : s1_data;
      end
    end
  end
endmodule

// File: rtl/bridge_mem_chk.sv
module bridge_mem_chk
  import bridge_mem_pkg::*;
#(
  parameter int                DATA_W    = 23,
  parameter int                DEPTH     = 16,
  parameter int                BUS_AW    = 16,
  parameter logic [BUS_AW-1:0] BASE_ADDR = 'h40,
  parameter bridge_mode_e      MODE      = BRIDGE_BIDIR,
  parameter int                IDX_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_in_valid,
  input logic              bus_in_write,
  input logic [BUS_AW-1:0] bus_in_addr,
  input logic [15:0]       bus_in_data,
  input logic              bus_out_valid,
  input logic              bus_out_write,
  input logic [BUS_AW-1:0] bus_out_addr,
  input logic [15:0]       bus_out_data,
  input logic [IDX_W-1:0]  usr_addr,
  input logic [DATA_W-1:0] usr_wdata,
  input logic              usr_we,
  input logic [DATA_W-1:0] usr_rdata
);
  localparam int NB     = bank_count(DATA_W);
  localparam int LAST_W = bank_width(DATA_W, NB - 1);
  localparam logic [BUS_AW:0] LO    = {1'b0, BASE_ADDR};
  localparam logic [BUS_AW:0] HI    = LO + (BUS_AW+1)'(NB * DEPTH);
  localparam logic [BUS_AW:0] TOPLO = LO + (BUS_AW+1)'((NB - 1) * DEPTH);

  logic out_miss;
  logic out_top;
  assign out_miss = ({1'b0, bus_out_addr} < LO) || ({1'b0, bus_out_addr} >= HI);
  assign out_top  = ({1'b0, bus_out_addr} >= TOPLO) && !out_miss;

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_in_valid |-> ##2 bus_out_valid);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> $past(bus_in_valid, 2));

  p_fields_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (bus_out_addr == $past(bus_in_addr, 2)) &&
                      (bus_out_write == $past(bus_in_write, 2)));

  p_write_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && bus_out_write) |-> bus_out_data == $past(bus_in_data, 2));

  p_miss_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && out_miss) |-> bus_out_data == $past(bus_in_data, 2));

  if (MODE == BRIDGE_HOST_TO_USER) begin : g_h2u
    p_read_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_out_valid |-> bus_out_data == $past(bus_in_data, 2));
  end

  if (MODE == BRIDGE_USER_TO_HOST) begin : g_u2h
    p_usr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rdata == '0);
  end

  if (MODE != BRIDGE_HOST_TO_USER && LAST_W < 16) begin : g_narrow
    p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_out_valid && !bus_out_write && out_top) |->
        bus_out_data[15:LAST_W] == '0);
  end

  if (MODE == BRIDGE_BIDIR) begin : g_bidir
    p_user_wr_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(usr_we, 2) && ($past(usr_addr, 1) == $past(usr_addr, 2))) |->
        usr_rdata == $past(usr_wdata, 2));
  end
endmodule

bind bridge_mem bridge_mem_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .BUS_AW(BUS_AW),
  .BASE_ADDR(BASE_ADDR), .MODE(MODE), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_in_valid(bus_in_valid), .bus_in_write(bus_in_write),
  .bus_in_addr(bus_in_addr), .bus_in_data(bus_in_data),
  .bus_out_valid(bus_out_valid), .bus_out_write(bus_out_write),
  .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
  .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we),
  .usr_rdata(usr_rdata)
);

// File: tb/test_bridge_mem.sv
`timescale 1ns/1ps
module test_bridge_mem;
  import bridge_mem_pkg::*;

  localparam int          DATA_W = 23;
  localparam int          DEPTH  = 16;
  localparam int          BUS_AW = 16;
  localparam logic [15:0] BASE   = 16'h0040;
  localparam int          NB     = 2;
  localparam int          LAST_W = 7;
  localparam int          NI     = 3;

  // instance 0: bidirectional, 1: user-to-host, 2: host-to-user
  localparam bit BUS_WR_OK [NI] = '{1, 0, 1};
  localparam bit BUS_RD_OK [NI] = '{1, 1, 0};
  localparam bit USR_WR_OK [NI] = '{1, 1, 0};
  localparam bit USR_RD_OK [NI] = '{1, 0, 1};

  logic clk = 0;
  logic rst_n = 0;
  logic bi_valid = 0, bi_write = 0;
  logic [15:0] bi_addr = '0, bi_data = '0;
  logic [3:0] usr_addr = '0;
  logic [DATA_W-1:0] usr_wdata = '0;
  logic usr_we = 0;

  logic              bo_valid [NI];
  logic              bo_write [NI];
  logic [15:0]       bo_addr  [NI];
  logic [15:0]       bo_data  [NI];
  logic [DATA_W-1:0] u_rdata  [NI];

  always #2 clk = ~clk;

  bridge_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BUS_AW(BUS_AW),
    .BASE_ADDR(BASE), .MODE(BRIDGE_BIDIR)) i_bridge_mem (
    .clk(clk), .rst_n(rst_n), .bus_in_valid(bi_valid), .bus_in_write(bi_write),
    .bus_in_addr(bi_addr), .bus_in_data(bi_data), .bus_out_valid(bo_valid[0]),
    .bus_out_write(bo_write[0]), .bus_out_addr(bo_addr[0]), .bus_out_data(bo_data[0]),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we), .usr_rdata(u_rdata[0]));

  bridge_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BUS_AW(BUS_AW),
    .BASE_ADDR(BASE), .MODE(BRIDGE_USER_TO_HOST)) i_bridge_mem_u2h (
    .clk(clk), .rst_n(rst_n), .bus_in_valid(bi_valid), .bus_in_write(bi_write),
    .bus_in_addr(bi_addr), .bus_in_data(bi_data), .bus_out_valid(bo_valid[1]),
    .bus_out_write(bo_write[1]), .bus_out_addr(bo_addr[1]), .bus_out_data(bo_data[1]),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we), .usr_rdata(u_rdata[1]));

  bridge_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BUS_AW(BUS_AW),
    .BASE_ADDR(BASE), .MODE(BRIDGE_HOST_TO_USER)) i_bridge_mem_h2u (
    .clk(clk), .rst_n(rst_n), .bus_in_valid(bi_valid), .bus_in_write(bi_write),
    .bus_in_addr(bi_addr), .bus_in_data(bi_data), .bus_out_valid(bo_valid[2]),
    .bus_out_write(bo_write[2]), .bus_out_addr(bo_addr[2]), .bus_out_data(bo_data[2]),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we), .usr_rdata(u_rdata[2]));

  logic [15:0] mdl [NI][NB][DEPTH];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic bit in_win(logic [15:0] a);
    return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + NB * DEPTH);
  endfunction

  function automatic logic [15:0] lane_mask(int b);
    return (b == NB - 1) ? 16'((1 << LAST_W) - 1) : 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_bus(int i, logic [15:0] a, logic [15:0] carried);
    int off;
    off = int'(a) - int'(BASE);
    if (in_win(a) && BUS_RD_OK[i]) return mdl[i][off / DEPTH][off % DEPTH];
    return carried;
  endfunction

  function automatic logic [DATA_W-1:0] exp_usr(int i, int a);
    logic [NB*16-1:0] acc;
    acc = '0;
    if (!USR_RD_OK[i]) return '0;
    for (int b = 0; b < NB; b++) acc[16*b +: 16] = mdl[i][b][a];
    return acc[DATA_W-1:0];
  endfunction

  task automatic cmp(string tag, int i, logic [31:0] act, logic [31:0] exp);
    string mtag;
    mtag = (i == 1) ? " R10" : (i == 2) ? " R9" : "";
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s%s inst%0d actual=%h expected=%h", tag, mtag, i, act, exp);
    end
  endtask

  task automatic model_bus_wr(logic [15:0] a, logic [15:0] d);
    int off;
    off = int'(a) - int'(BASE);
    for (int i = 0; i < NI; i++)
      if (BUS_WR_OK[i] && in_win(a))
        mdl[i][off / DEPTH][off % DEPTH] = d & lane_mask(off / DEPTH);
  endtask

  task automatic model_usr_wr(int a, logic [DATA_W-1:0] d);
    logic [NB*16-1:0] ext;
    ext = (NB*16)'(d);
    for (int i = 0; i < NI; i++)
      if (USR_WR_OK[i])
        for (int b = 0; b < NB; b++) mdl[i][b][a] = ext[16*b +: 16] & lane_mask(b);
  endtask

  task automatic bus_rd(logic [15:0] a, string req);
    logic [15:0] carried;
    carried = 16'hC0DE ^ a;
    @(negedge clk);
    bi_valid = 1; bi_write = 0; bi_addr = a; bi_data = carried;
    @(negedge clk);
    bi_valid = 0;
    for (int i = 0; i < NI; i++) cmp({req, " R4 early"}, i, 32'(bo_valid[i]), 0);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      cmp({req, " R4 valid"}, i, 32'(bo_valid[i]), 1);
      cmp({req, " R4 addr"}, i, 32'(bo_addr[i]), 32'(a));
      cmp({req, " R5 data"}, i, 32'(bo_data[i]), 32'(exp_bus(i, a, carried)));
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [15:0] d, string req);
    @(negedge clk);
    bi_valid = 1; bi_write = 1; bi_addr = a; bi_data = d;
    @(negedge clk);
    bi_valid = 0;
    model_bus_wr(a, d);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      cmp({req, " R4 wflag"}, i, 32'(bo_write[i]), 1);
      cmp({req, " R5 wdata"}, i, 32'(bo_data[i]), 32'(d));
    end
  endtask

  task automatic usr_wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    usr_addr = 4'(a); usr_wdata = d; usr_we = 1;
    @(negedge clk);
    usr_we = 0;
    model_usr_wr(a, d);
  endtask

  task automatic usr_rd(int a, string req);
    @(negedge clk);
    usr_addr = 4'(a);
    @(negedge clk);
    for (int i = 0; i < NI; i++) cmp(req, i, 32'(u_rdata[i]), 32'(exp_usr(i, a)));
  endtask

  task automatic t_reset();
    for (int i = 0; i < NI; i++) begin
      cmp("R1 out_valid", i, 32'(bo_valid[i]), 0);
      cmp("R1 usr_rdata", i, 32'(u_rdata[i]), 0);
    end
    for (int a = 0; a < NB * DEPTH; a++) bus_rd(BASE + 16'(a), "R1 zero");
    usr_rd(DEPTH - 1, "R1 user zero");
  endtask

  task automatic t_bus_fill();
    for (int a = 0; a < NB * DEPTH; a++)
      bus_wr(BASE + 16'(a), 16'(a * 16'h9E37) ^ 16'h5A5A, "R2 fill");
    for (int a = NB * DEPTH - 1; a >= 0; a--) bus_rd(BASE + 16'(a), "R2 readback");
    for (int a = 0; a < DEPTH; a += 5) usr_rd(a, "R2 user view");
  endtask

  task automatic t_user_to_bus();
    usr_wr(3, 23'h5ABCDE);
    bus_rd(BASE + 16'd3, "R2 low slice");
    bus_rd(BASE + 16'(DEPTH + 3), "R2 high slice R3");
    usr_wr(0, 23'h7FFFFF);
    usr_wr(15, 23'h000001);
    usr_rd(0, "R7 user read");
    usr_rd(15, "R7 user read end");
    bus_rd(BASE, "R2 entry0");
    bus_rd(BASE + 16'(NB * DEPTH - 1), "R2 last entry R3");
  endtask

  task automatic t_bus_to_user();
    bus_wr(BASE + 16'd7, 16'h1234, "R2 lo");
    bus_wr(BASE + 16'(DEPTH + 7), 16'hFFFF, "R3 hi wide data");
    usr_rd(7, "R2 assembled R3");
    bus_rd(BASE + 16'(DEPTH + 7), "R3 zero-extend");
  endtask

  task automatic t_out_of_range();
    bus_wr(BASE - 16'd1, 16'hDEAD, "R6 below");
    bus_wr(BASE + 16'(NB * DEPTH), 16'hBEEF, "R6 above");
    bus_wr(16'hFFFF, 16'h0BAD, "R6 top");
    bus_rd(BASE - 16'd1, "R6 pass below");
    bus_rd(BASE + 16'(NB * DEPTH), "R6 pass above");
    bus_rd(BASE, "R6 untouched first");
    bus_rd(BASE + 16'(NB * DEPTH - 1), "R6 untouched last");
    usr_rd(15, "R6 user untouched");
  endtask

  task automatic t_user_b2b();
    usr_wr(9, 23'h123456);
    usr_wr(10, 23'h654321);
    @(negedge clk);
    usr_addr = 4'd9;
    @(negedge clk);
    usr_addr = 4'd10;
    for (int i = 0; i < NI; i++) cmp("R7 b2b first", i, 32'(u_rdata[i]), 32'(exp_usr(i, 9)));
    @(negedge clk);
    for (int i = 0; i < NI; i++) cmp("R7 b2b second", i, 32'(u_rdata[i]), 32'(exp_usr(i, 10)));
  endtask

  task automatic t_collide();
    @(negedge clk);
    bi_valid = 1; bi_write = 1; bi_addr = BASE + 16'd5; bi_data = 16'hAAAA;
    usr_addr = 4'd5; usr_wdata = 23'h155555; usr_we = 1;
    @(negedge clk);
    bi_valid = 0; usr_we = 0;
    model_bus_wr(BASE + 16'd5, 16'hAAAA);
    model_usr_wr(5, 23'h155555);
    @(negedge clk);
    usr_rd(5, "R8 user wins");
    bus_rd(BASE + 16'd5, "R8 bus view");
  endtask

  initial begin
    for (int i = 0; i < NI; i++)
      for (int b = 0; b < NB; b++)
        for (int e = 0; e < DEPTH; e++) mdl[i][b][e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bus_fill();
    t_user_to_bus();
    t_bus_to_user();
    t_out_of_range();
    t_user_b2b();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule